// File: doc/BRIEF.md
# SDRAM Command Bus Rule Monitor

This block watches the command pins of a single-data-rate SDRAM bus without driving anything. It decodes each clock's command, keeps a model of which of the four banks hold an open row, and keeps saturating cycle counters since each bank's last row activation and last precharge. Every command is then judged against ordering rules and minimum spacings. Ordering rules cover open and closed banks, the all-banks-idle precondition, the mode-set quiet gap and the auto-precharge lockout. Spacings are parameters in clock cycles.

When a command breaks a rule, the monitor raises a sticky flag, records a code for the first rule broken since the last clear, and counts offending commands. It is meant to sit beside a memory controller in simulation or in hardware as a protocol watchdog. The outputs are registered, so a verdict on the command sampled at edge N appears after edge N.

Top module: `sdram_cmd_monitor`

## Requirements
- R1: The command is decoded from {cs_n,ras_n,cas_n,we_n}. 0011 is row activate, 0101 is read, 0100 is write, 0010 is precharge, 0001 is refresh, 0000 is mode set and 0110 is burst stop. Any pattern with cs_n high, and 0111, is a no-operation, and a no-operation never counts as a violation.
- R2: A command sampled at an edge where cke was low at the previous edge is ignored completely.
- R3: A read or write to a bank fewer than T_RCD cycles after that bank's activate gives code 7.
- R4: A precharge fewer than T_RAS cycles after the activate of any open bank it closes gives code 8. A single-bank precharge closes bank ba. A precharge with a10 high closes all banks.
- R5: An activate fewer than T_RC cycles after the same bank's previous activate gives code 9. Otherwise, an activate fewer than T_RP cycles after the precharge that closed the bank gives code 10.
- R6: An activate fewer than T_RRD cycles after an activate to any other bank gives code 11.
- R7: A read, write or single-bank precharge to a closed bank gives code 2. An activate to an open bank gives code 3. A precharge with a10 high leaves every bank closed.
- R8: A mode set while any bank is open gives code 4. A refresh while any bank is open gives code 5.
- R9: Any command other than a no-operation within MRS_GAP cycles after a mode set gives code 1. A command exactly MRS_GAP+1 cycles later is legal.
- R10: A read or write with a10 high at cycle t starts a burst of BURST_LEN cycles. A read or write to that bank at t+k with 0<k<BURST_LEN gives code 6. At t+BURST_LEN the bank is closed, and an activate to it at t+BURST_LEN+j with j<T_RP gives code 10.
- R11: Reads and writes to an open bank on consecutive cycles, in any mix, are legal.
- R12: err_flag is sticky. err_code holds the first violation's code. When one command breaks several rules, the code is chosen in the order 1, then 2 to 5, then 6, then 7 to 11. err_count counts offending commands and saturates. clr_err resets all three, but a violation in the same cycle is still recorded. Outputs change one cycle after the command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst | input | 1 | Synchronous active-high reset |
| clr_err | input | 1 | Synchronous clear of flag, code and count |
| cke | input | 1 | Clock enable pin of the bus |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe, active low |
| cas_n | input | 1 | Column strobe, active low |
| we_n | input | 1 | Write enable, active low |
| ba | input | BA_W | Bank address |
| a10 | input | 1 | Address bit 10: auto-precharge / precharge-all |
| err_flag | output | 1 | Sticky violation flag |
| err_code | output | 4 | Code of the first violation since clear |
| err_count | output | CNT_W | Number of offending commands, saturating |

## Verification
The embedded properties check on every cycle that the flag stays set and the code holds until a clear, and that the count only moves on a violation. They also check that a clock-suspended cycle decodes as idle, that an activate opens its bank, and that a precharge closes it. They check that a pending auto-precharge bank is open and that any command in the cycle right after a mode set is reported. The exact spacing thresholds cannot be shown by a property, and neither can the priority between simultaneous rule breaks or the end of the auto-precharge burst. These are shown by the bench, which sweeps command distances across each limit for every bank and bank pair and compares against codes derived from the parameters.

// File: rtl/sdram_mon_pkg.sv
package sdram_mon_pkg;

  typedef enum logic [2:0] {
    C_NOP, C_ACT, C_RD, C_WR, C_PRE, C_REF, C_MRS, C_BST
  } cmd_e;

  typedef enum logic [3:0] {
    E_NONE     = 4'd0,
    E_MRS_GAP  = 4'd1,
    E_NOT_OPEN = 4'd2,
    E_ACT_OPEN = 4'd3,
    E_MRS_BUSY = 4'd4,
    E_REF_BUSY = 4'd5,
    E_AP_LOCK  = 4'd6,
    E_TRCD     = 4'd7,
    E_TRAS     = 4'd8,
    E_TRC      = 4'd9,
    E_TRP      = 4'd10,
    E_TRRD     = 4'd11
  } err_e;

  function automatic cmd_e decode_cmd(input logic cs_n, input logic ras_n,
                                      input logic cas_n, input logic we_n);
    cmd_e c;
    if (cs_n) c = C_NOP;
    else begin
      case ({ras_n, cas_n, we_n})
        3'b011:  c = C_ACT;
        3'b101:  c = C_RD;
        3'b100:  c = C_WR;
        3'b010:  c = C_PRE;
        3'b001:  c = C_REF;
        3'b000:  c = C_MRS;
        3'b110:  c = C_BST;
        default: c = C_NOP;
      endcase
    end
    return c;
  endfunction

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/sdram_cmd_decode.sv
module sdram_cmd_decode
  import sdram_mon_pkg::*;
#(
  parameter int BA_W = 2
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            cke,
  input  logic            cs_n,
  input  logic            ras_n,
  input  logic            cas_n,
  input  logic            we_n,
  input  logic [BA_W-1:0] ba,
  input  logic            a10,
  output cmd_e            cmd,
  output logic [BA_W-1:0] cmd_ba,
  output logic            cmd_a10
);

  logic cke_q;

  always_ff @(posedge clk) begin
    if (rst) cke_q <= 1'b1;
    else     cke_q <= cke;
  end

  always_comb begin
    cmd     = cke_q ? decode_cmd(cs_n, ras_n, cas_n, we_n) : C_NOP;
    cmd_ba  = ba;
    cmd_a10 = a10;
  end

  // R2: a cycle following a low clock enable is decoded as idle
  assert_cke_gate_R2: assert property (@(posedge clk) disable iff (rst)
    ($past(!cke) && $past(!rst)) |-> (cmd == C_NOP));

endmodule

// File: rtl/sdram_bank_track.sv
module sdram_bank_track
  import sdram_mon_pkg::*;
#(
  parameter int CYC_W     = 4,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  cmd_e             cmd,
  input  logic             hit,
  input  logic             a10,
  output logic             is_open,
  output logic             ap_lock,
  output logic [CYC_W-1:0] act_cnt,
  output logic [CYC_W-1:0] pre_dist
);

  localparam int BL_W = (BURST_LEN > 1) ? $clog2(BURST_LEN) : 1;
  localparam logic [CYC_W-1:0] CNT_MAX = '1;
  localparam logic [CYC_W-1:0] CNT_ONE = CYC_W'(1);
  localparam logic [BL_W-1:0]  BL_LAST = BL_W'(BURST_LEN - 1);

  logic             open_q, pend_q;
  logic [BL_W-1:0]  left_q;
  logic [CYC_W-1:0] act_q, pre_q;
  logic             ap_done, do_act, do_pre, do_col;

  always_comb begin
    ap_done  = pend_q && (left_q == '0);
    is_open  = open_q && !ap_done;
    ap_lock  = pend_q && (left_q != '0);
    act_cnt  = act_q;
    pre_dist = ap_done ? '0 : pre_q;
    do_act   = (cmd == C_ACT) && hit;
    do_pre   = (cmd == C_PRE) && (hit || a10);
    do_col   = ((cmd == C_RD) || (cmd == C_WR)) && hit;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      open_q <= 1'b0;
      pend_q <= 1'b0;
      left_q <= '0;
      act_q  <= CNT_MAX;
      pre_q  <= CNT_MAX;
    end else begin
      if (do_act)                act_q <= CNT_ONE;
      else if (act_q != CNT_MAX) act_q <= act_q + 1'b1;

      if (do_pre || ap_done)     pre_q <= CNT_ONE;
      else if (pre_q != CNT_MAX) pre_q <= pre_q + 1'b1;

      if (ap_lock) left_q <= left_q - 1'b1;

      if (do_act) begin
        open_q <= 1'b1;
        pend_q <= 1'b0;
      end else if (do_pre || ap_done) begin
        open_q <= 1'b0;
        pend_q <= 1'b0;
      end else if (do_col && a10 && is_open && !ap_lock) begin
        pend_q <= 1'b1;
        left_q <= BL_LAST;
      end
    end
  end

  // R7: an activate leaves the bank open
  assert_act_opens_R7: assert property (@(posedge clk) disable iff (rst)
    do_act |=> is_open || ap_lock);

  // R7: a precharge covering this bank leaves it closed
  assert_pre_closes_R7: assert property (@(posedge clk) disable iff (rst)
    (do_pre && !do_act) |=> !is_open);

  // R10: a pending auto-precharge burst only exists on an open row
  assert_pend_open_R10: assert property (@(posedge clk) disable iff (rst)
    pend_q |-> open_q);

endmodule

// File: rtl/sdram_rule_check.sv
module sdram_rule_check
  import sdram_mon_pkg::*;
#(
  parameter int NB      = 4,
  parameter int BA_W    = 2,
  parameter int CYC_W   = 4,
  parameter int T_RCD   = 3,
  parameter int T_RRD   = 2,
  parameter int T_RC    = 7,
  parameter int T_RAS   = 5,
  parameter int T_RP    = 3,
  parameter int MRS_GAP = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  cmd_e                    cmd,
  input  logic [BA_W-1:0]         ba,
  input  logic                    a10,
  input  logic [NB-1:0]           is_open,
  input  logic [NB-1:0]           ap_lock,
  input  logic [NB-1:0][CYC_W-1:0] act_cnt,
  input  logic [NB-1:0][CYC_W-1:0] pre_dist,
  output logic                    viol,
  output err_e                    code
);

  localparam logic [CYC_W-1:0] L_RCD = CYC_W'(T_RCD);
  localparam logic [CYC_W-1:0] L_RRD = CYC_W'(T_RRD);
  localparam logic [CYC_W-1:0] L_RC  = CYC_W'(T_RC);
  localparam logic [CYC_W-1:0] L_RAS = CYC_W'(T_RAS);
  localparam logic [CYC_W-1:0] L_RP  = CYC_W'(T_RP);
  localparam logic [CYC_W-1:0] L_GAP = CYC_W'(MRS_GAP);
  localparam logic [CYC_W-1:0] CNT_MAX = '1;

  logic [CYC_W-1:0] mrs_q;
  logic             sel_open, sel_lock, any_open, tras_bad, rrd_bad;

  always_ff @(posedge clk) begin
    if (rst)                   mrs_q <= CNT_MAX;
    else if (cmd == C_MRS)     mrs_q <= CYC_W'(1);
    else if (mrs_q != CNT_MAX) mrs_q <= mrs_q + 1'b1;
  end

  always_comb begin
    sel_open = is_open[ba];
    sel_lock = ap_lock[ba];
    any_open = |is_open;
    tras_bad = 1'b0;
    rrd_bad  = 1'b0;
    for (int b = 0; b < NB; b++) begin
      if (is_open[b] && (a10 || (ba == BA_W'(b))) && (act_cnt[b] < L_RAS))
        tras_bad = 1'b1;
      if ((ba != BA_W'(b)) && (act_cnt[b] < L_RRD))
        rrd_bad = 1'b1;
    end

    code = E_NONE;
    if ((cmd != C_NOP) && (mrs_q <= L_GAP)) code = E_MRS_GAP;
    else begin
      case (cmd)
        C_ACT: begin
          if (sel_open)                 code = E_ACT_OPEN;
          else if (act_cnt[ba] < L_RC)  code = E_TRC;
          else if (pre_dist[ba] < L_RP) code = E_TRP;
          else if (rrd_bad)             code = E_TRRD;
        end
        C_RD, C_WR: begin
          if (!sel_open)                code = E_NOT_OPEN;
          else if (sel_lock)            code = E_AP_LOCK;
          else if (act_cnt[ba] < L_RCD) code = E_TRCD;
        end
        C_PRE: begin
          if (!a10 && !sel_open)        code = E_NOT_OPEN;
          else if (tras_bad)            code = E_TRAS;
        end
        C_REF:   if (any_open) code = E_REF_BUSY;
        C_MRS:   if (any_open) code = E_MRS_BUSY;
        default: code = E_NONE;
      endcase
    end
    viol = (code != E_NONE);
  end

  // R1: an idle cycle is never reported
  assert_nop_clean_R1: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_NOP) |-> !viol);

  // R9: whatever follows a mode set on the next cycle is idle or reported
  assert_mrs_gap_R9: assert property (@(posedge clk) disable iff (rst)
    (cmd == C_MRS) |=> ((cmd == C_NOP) || viol));

endmodule

// File: rtl/sdram_cmd_monitor.sv
module sdram_cmd_monitor
  import sdram_mon_pkg::*;
#(
  parameter int BA_W      = 2,
  parameter int CNT_W     = 8,
  parameter int T_RCD     = 3,
  parameter int T_RRD     = 2,
  parameter int T_RC      = 7,
  parameter int T_RAS     = 5,
  parameter int T_RP      = 3,
  parameter int MRS_GAP   = 2,
  parameter int BURST_LEN = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clr_err,
  input  logic             cke,
  input  logic             cs_n,
  input  logic             ras_n,
  input  logic             cas_n,
  input  logic             we_n,
  input  logic [BA_W-1:0]  ba,
  input  logic             a10,
  output logic             err_flag,
  output logic [3:0]       err_code,
  output logic [CNT_W-1:0] err_count
);

  localparam int NB    = 1 << BA_W;
  localparam int T_TOP = imax(imax(imax(T_RCD, T_RRD), imax(T_RC, T_RAS)),
                              imax(T_RP, MRS_GAP + 1));
  localparam int CYC_W = $clog2(T_TOP + 2);
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  cmd_e                     cmd;
  logic [BA_W-1:0]          cmd_ba;
  logic                     cmd_a10;
  logic [NB-1:0]            bank_open, bank_lock;
  logic [NB-1:0][CYC_W-1:0] bank_act, bank_pre;
  logic                     viol;
  err_e                     code_n;

  sdram_cmd_decode #(.BA_W(BA_W)) u_dec (
    .clk(clk), .rst(rst), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
    .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .cmd(cmd), .cmd_ba(cmd_ba), .cmd_a10(cmd_a10)
  );

  for (genvar g = 0; g < NB; g++) begin : g_bank
    sdram_bank_track #(.CYC_W(CYC_W), .BURST_LEN(BURST_LEN)) u_bank (
      .clk(clk), .rst(rst), .cmd(cmd),
      .hit(cmd_ba == BA_W'(g)), .a10(cmd_a10),
      .is_open(bank_open[g]), .ap_lock(bank_lock[g]),
      .act_cnt(bank_act[g]), .pre_dist(bank_pre[g])
    );
  end

  sdram_rule_check #(
    .NB(NB), .BA_W(BA_W), .CYC_W(CYC_W), .T_RCD(T_RCD), .T_RRD(T_RRD),
    .T_RC(T_RC), .T_RAS(T_RAS), .T_RP(T_RP), .MRS_GAP(MRS_GAP)
  ) u_rules (
    .clk(clk), .rst(rst), .cmd(cmd), .ba(cmd_ba), .a10(cmd_a10),
    .is_open(bank_open), .ap_lock(bank_lock),
    .act_cnt(bank_act), .pre_dist(bank_pre),
    .viol(viol), .code(code_n)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_flag  <= 1'b0;
      err_code  <= E_NONE;
      err_count <= '0;
    end else if (clr_err) begin
      err_flag  <= viol;
      err_code  <= viol ? code_n : E_NONE;
      err_count <= viol ? CNT_W'(1) : '0;
    end else if (viol) begin
      err_flag <= 1'b1;
      if (!err_flag) err_code <= code_n;
      if (err_count != CNT_MAX) err_count <= err_count + 1'b1;
    end
  end

  // R12: flag stays set until a clear
  assert_flag_sticky_R12: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr_err) |=> err_flag);

  // R12: first code is held while the flag is up
  assert_code_hold_R12: assert property (@(posedge clk) disable iff (rst)
    (err_flag && !clr_err) |=> $stable(err_code));

  // R12: the count moves only on a violation or a clear
  assert_count_quiet_R12: assert property (@(posedge clk) disable iff (rst)
    (!clr_err && !viol) |=> $stable(err_count));

endmodule

// File: tb/tb_sdram_cmd_monitor.sv
module tb_sdram_cmd_monitor;

  localparam int CLK_P = 10;
  localparam int RCD = 3, RRD = 2, RC = 7, RAS = 5, RP = 3, GAP = 2, BL = 4;

  localparam logic [3:0] K_NOP = 4'b0111, K_ACT = 4'b0011, K_RD = 4'b0101,
                         K_WR = 4'b0100, K_PRE = 4'b0010, K_REF = 4'b0001,
                         K_MRS = 4'b0000;

  logic clk = 1'b0, rst = 1'b1, clr_err = 1'b0, cke = 1'b1;
  logic cs_n = 1'b1, ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
  logic [1:0] ba = '0;
  logic a10 = 1'b0;
  logic err_flag;
  logic [3:0] err_code;
  logic [7:0] err_count;
  int n_run = 0, n_fail = 0;

  always #(CLK_P/2) clk = ~clk;

  sdram_cmd_monitor #(
    .BA_W(2), .CNT_W(8), .T_RCD(RCD), .T_RRD(RRD), .T_RC(RC), .T_RAS(RAS),
    .T_RP(RP), .MRS_GAP(GAP), .BURST_LEN(BL)
  ) dut (
    .clk(clk), .rst(rst), .clr_err(clr_err), .cke(cke), .cs_n(cs_n),
    .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .ba(ba), .a10(a10),
    .err_flag(err_flag), .err_code(err_code), .err_count(err_count)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] c, input logic [1:0] b, input logic a);
    @(negedge clk);
    {cs_n, ras_n, cas_n, we_n} = c;
    ba = b;
    a10 = a;
  endtask

  task automatic idle(input int k);
    for (int i = 0; i < k; i++) drive(K_NOP, 2'd0, 1'b0);
  endtask

  task automatic fresh();
    @(negedge clk);
    rst = 1'b1; cke = 1'b1; clr_err = 1'b0;
    {cs_n, ras_n, cas_n, we_n} = K_NOP;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic expect_state(input string tag, input int code, input int cnt);
    idle(1);
    chk({tag, " flag"}, int'(err_flag), int'(code != 0));
    chk({tag, " code"}, int'(err_code), code);
    chk({tag, " count"}, int'(err_count), cnt);
  endtask

  initial begin
    #(CLK_P * 150000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    // R12 reset state
    fresh();
    expect_state("R12 reset", 0, 0);

    // R1: chip select high masks every pattern; 0111 is idle too
    fresh();
    for (int p = 0; p < 8; p++) drive({1'b1, 3'(p)}, 2'd1, 1'b1);
    drive(K_NOP, 2'd2, 1'b1);
    expect_state("R1 deselect", 0, 0);

    // R3: activate-to-column spacing, every bank
    for (int b = 0; b < 4; b++)
      for (int d = 1; d <= 6; d++) begin
        fresh();
        drive(K_ACT, 2'(b), 1'b0);
        idle(d - 1);
        drive((d % 2) ? K_RD : K_WR, 2'(b), 1'b0);
        expect_state("R3 trcd", (d < RCD) ? 7 : 0, (d < RCD) ? 1 : 0);
      end

    // R4: activate-to-precharge, single and all-bank
    for (int d = 1; d <= 7; d++) begin
      fresh();
      drive(K_ACT, 2'd0, 1'b0);
      idle(d - 1);
      drive(K_PRE, (d % 2) ? 2'd0 : 2'd3, 1'(d % 2 == 0));
      expect_state("R4 tras", (d < RAS) ? 8 : 0, (d < RAS) ? 1 : 0);
    end

    // R5: same-bank cycle time, then precharge recovery
    for (int p = RAS; p <= RAS + 1; p++)
      for (int q = 1; q <= 5; q++) begin
        int e;
        fresh();
        drive(K_ACT, 2'd1, 1'b0);
        idle(p - 1);
        drive(K_PRE, 2'd1, 1'b0);
        idle(q - 1);
        drive(K_ACT, 2'd1, 1'b0);
        e = (p + q < RC) ? 9 : ((q < RP) ? 10 : 0);
        expect_state("R5 trc/trp", e, (e != 0) ? 1 : 0);
      end

    // R6: activate spacing across every ordered bank pair
    for (int b1 = 0; b1 < 4; b1++)
      for (int b2 = 0; b2 < 4; b2++)
        if (b1 != b2)
          for (int d = 1; d <= 3; d++) begin
            fresh();
            drive(K_ACT, 2'(b1), 1'b0);
            idle(d - 1);
            drive(K_ACT, 2'(b2), 1'b0);
            expect_state("R6 trrd", (d < RRD) ? 11 : 0, (d < RRD) ? 1 : 0);
          end

    // R7: closed-bank column and precharge, re-activate of open bank
    fresh();
    drive(K_RD, 2'd2, 1'b0);
    expect_state("R7 read closed", 2, 1);
    fresh();
    drive(K_PRE, 2'd3, 1'b0);
    expect_state("R7 pre closed", 2, 1);
    fresh();
    drive(K_ACT, 2'd0, 1'b0);
    idle(RC - 1);
    drive(K_ACT, 2'd0, 1'b0);
    expect_state("R7 act open", 3, 1);
    // R7: all-bank precharge addressed at bank 2 closes bank 0
    fresh();
    drive(K_ACT, 2'd0, 1'b0);
    idle(1);
    drive(K_ACT, 2'd2, 1'b0);
    idle(RAS);
    drive(K_PRE, 2'd2, 1'b1);
    idle(2);
    drive(K_RD, 2'd0, 1'b0);
    expect_state("R7 pre all", 2, 1);

    // R8: mode set and refresh need every bank idle
    fresh();
    drive(K_ACT, 2'd1, 1'b0);
    idle(4);
    drive(K_MRS, 2'd0, 1'b0);
    expect_state("R8 mrs busy", 4, 1);
    fresh();
    drive(K_ACT, 2'd3, 1'b0);
    idle(4);
    drive(K_REF, 2'd0, 1'b0);
    expect_state("R8 ref busy", 5, 1);

    // R9: quiet gap after mode set
    for (int d = 1; d <= 4; d++) begin
      fresh();
      drive(K_MRS, 2'd0, 1'b0);
      idle(d - 1);
      drive(K_REF, 2'd0, 1'b0);
      expect_state("R9 mrs gap", (d <= GAP) ? 1 : 0, (d <= GAP) ? 1 : 0);
    end

    // R10: auto-precharge lockout, then closed after the burst
    for (int k = 1; k <= 6; k++) begin
      fresh();
      drive(K_ACT, 2'd1, 1'b0);
      idle(RCD - 1);
      drive(K_RD, 2'd1, 1'b1);
      idle(k - 1);
      drive(K_RD, 2'd1, 1'b0);
      expect_state("R10 ap lock", (k < BL) ? 6 : 2, 1);
    end
    // R10: precharge recovery counted from the burst end
    for (int j = 0; j <= 4; j++) begin
      fresh();
      drive(K_ACT, 2'd1, 1'b0);
      idle(RCD - 1);
      drive(K_WR, 2'd1, 1'b1);
      idle(BL + j - 1);
      drive(K_ACT, 2'd1, 1'b0);
      expect_state("R10 ap trp", (j < RP) ? 10 : 0, (j < RP) ? 1 : 0);
    end

    // R11: back-to-back column commands
    fresh();
    drive(K_ACT, 2'd0, 1'b0);
    idle(RCD - 1);
    drive(K_RD, 2'd0, 1'b0);
    drive(K_RD, 2'd0, 1'b0);
    drive(K_WR, 2'd0, 1'b0);
    drive(K_WR, 2'd0, 1'b0);
    drive(K_RD, 2'd0, 1'b0);
    expect_state("R11 tccd", 0, 0);

    // R2: command after a low clock enable is ignored
    fresh();
    @(negedge clk);
    cke = 1'b0; {cs_n, ras_n, cas_n, we_n} = K_NOP;
    @(negedge clk);
    cke = 1'b1; {cs_n, ras_n, cas_n, we_n} = K_RD; ba = 2'd2;
    expect_state("R2 suspend", 0, 0);
    drive(K_RD, 2'd2, 1'b0);
    expect_state("R2 resume", 2, 1);

    // R12: first code held, count, priority, clear
    fresh();
    drive(K_RD, 2'd0, 1'b0);
    drive(K_PRE, 2'd1, 1'b0);
    drive(K_ACT, 2'd2, 1'b0);
    drive(K_REF, 2'd0, 1'b0);
    expect_state("R12 first held", 2, 3);
    @(negedge clk);
    clr_err = 1'b1; {cs_n, ras_n, cas_n, we_n} = K_NOP;
    @(negedge clk);
    clr_err = 1'b0;
    chk("R12 clear flag", int'(err_flag), 0);
    chk("R12 clear code", int'(err_code), 0);
    chk("R12 clear count", int'(err_count), 0);
    @(negedge clk);
    clr_err = 1'b1; {cs_n, ras_n, cas_n, we_n} = K_RD; ba = 2'd1;
    @(negedge clk);
    clr_err = 1'b0; {cs_n, ras_n, cas_n, we_n} = K_NOP;
    chk("R12 clear+viol code", int'(err_code), 2);
    chk("R12 clear+viol count", int'(err_count), 1);
    fresh();
    drive(K_MRS, 2'd0, 1'b0);
    drive(K_RD, 2'd3, 1'b0);
    expect_state("R12 priority", 1, 1);

    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule